// File: doc/BRIEF.md
# Lane enable mask decoder

This block expands a compact lane-selection code into a full per-lane enable mask for a 32-lane, 16-bit-per-lane multiply-accumulate datapath. A 2-bit mode picks the kind of selection and a 5-bit value parameterizes it. The selection kinds are a parity pattern (all, odd-only, even-only or none), a single lane, a run of lanes from the bottom, or a run of lanes from the top. The decoder is purely combinational. An engine places one copy on its X lane path and a second copy on its Y lane path.

Lane 0 is the lowest-addressed 16-bit lane, and bit k of the mask enables lane k. In the run modes a value of zero selects every lane rather than none, so a full-width operation needs no special code. All 128 combinations of mode and value give a defined mask.

Top module: `lane_mask_decoder`

## Requirements
- R1: With mode 0 and value 0, every bit of the mask is 1.
- R2: With mode 0 and value 1, exactly the odd-numbered lanes are enabled (mask 32'hAAAA_AAAA).
- R3: With mode 0 and value 2, exactly the even-numbered lanes are enabled (mask 32'h5555_5555).
- R4: With mode 0 and any value from 3 to 31, the mask is all zeros.
- R5: With mode 1, only bit N of the mask is set, where N is the value (0..31).
- R6: With mode 2 and a nonzero value N, bits 0 through N-1 are set and all others are clear.
- R7: With mode 3 and a nonzero value N, bits 32-N through 31 are set and all others are clear.
- R8: With mode 2 or mode 3 and value 0, every bit of the mask is 1.
- R9: The mask depends only on the present mode and value and settles in the same cycle, with no memory of earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Selection kind: 0 parity, 1 single lane, 2 bottom run, 3 top run |
| value_i | input | 5 | Parameter N of the selection |
| mask_o | output | 32 | Lane enable mask, bit k enables lane k |

## Verification
The bench builds the decoder with its default of 32 lanes, which makes the value field 5 bits wide. The input space is then only 128 codes, so the bench walks it exhaustively in ascending and then descending order. This covers both extremes of each run mode (N=1 and N=31), the top and bottom lanes of the single-lane mode, and every undefined parity code. Each code is reached from two different predecessor codes, which exposes any dependence on earlier inputs.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    localparam int DEF_LANES = 32;
    localparam int DEF_VAL_W = $clog2(DEF_LANES);

    typedef enum logic [1:0] {
        SEL_PARITY = 2'd0,
        SEL_SINGLE = 2'd1,
        SEL_LOWRUN = 2'd2,
        SEL_HIGHRUN = 2'd3
    } sel_kind_e;

    localparam int PAR_ALL  = 0;
    localparam int PAR_ODD  = 1;
    localparam int PAR_EVEN = 2;

    // A lane index is odd when its lowest bit is set
    function automatic logic lane_is_odd(input int idx);
        return idx[0];
    endfunction

endpackage

// File: rtl/lmd_parity_gen.sv
module lmd_parity_gen
    import lmd_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int VAL_W = $clog2(LANES)
) (
    input  logic [VAL_W-1:0] code_i,
    output logic [LANES-1:0] mask_o
);
    logic want_all;
    logic want_odd;
    logic want_even;

    always_comb begin
        want_all  = (int'(code_i) == PAR_ALL);
        want_odd  = (int'(code_i) == PAR_ODD);
        want_even = (int'(code_i) == PAR_EVEN);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (lane_is_odd(k)) begin : g_odd
            assign mask_o[k] = want_all | want_odd;
        end else begin : g_even
            assign mask_o[k] = want_all | want_even;
        end
    end
endmodule

// File: rtl/lmd_onehot_gen.sv
module lmd_onehot_gen
    import lmd_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int VAL_W = $clog2(LANES)
) (
    input  logic [VAL_W-1:0] idx_i,
    output logic [LANES-1:0] mask_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [VAL_W-1:0] KIDX = VAL_W'(k);
        assign mask_o[k] = (idx_i == KIDX);
    end
endmodule

// File: rtl/lmd_span_gen.sv
module lmd_span_gen
    import lmd_pkg::*;
#(
    parameter int LANES     = DEF_LANES,
    parameter int VAL_W     = $clog2(LANES),
    parameter bit FROM_HIGH = 1'b0
) (
    input  logic [VAL_W-1:0] len_i,
    output logic [LANES-1:0] mask_o
);
    localparam int SUM_W = VAL_W + 1;
    localparam logic [SUM_W-1:0] LANE_TOTAL = SUM_W'(LANES);

    logic            len_zero;
    logic [SUM_W-1:0] len_ext;

    assign len_zero = (len_i == '0);
    assign len_ext  = {1'b0, len_i};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [SUM_W-1:0] KPOS = SUM_W'(k);
        if (FROM_HIGH) begin : g_top
            // lane k is within the top N when k + N reaches the lane count
            assign mask_o[k] = len_zero | ((KPOS + len_ext) >= LANE_TOTAL);
        end else begin : g_bottom
            assign mask_o[k] = len_zero | (KPOS < len_ext);
        end
    end
endmodule

// File: rtl/lane_mask_decoder.sv
module lane_mask_decoder
    import lmd_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int VAL_W = $clog2(LANES)
) (
    input  logic [1:0]       mode_i,
    input  logic [VAL_W-1:0] value_i,
    output logic [LANES-1:0] mask_o
);
    sel_kind_e        kind;
    logic [LANES-1:0] parity_mask;
    logic [LANES-1:0] single_mask;
    logic [LANES-1:0] low_mask;
    logic [LANES-1:0] high_mask;

    assign kind = sel_kind_e'(mode_i);

    lmd_parity_gen #(.LANES(LANES), .VAL_W(VAL_W)) u_parity (
        .code_i (value_i),
        .mask_o (parity_mask)
    );

    lmd_onehot_gen #(.LANES(LANES), .VAL_W(VAL_W)) u_single (
        .idx_i  (value_i),
        .mask_o (single_mask)
    );

    lmd_span_gen #(.LANES(LANES), .VAL_W(VAL_W), .FROM_HIGH(1'b0)) u_lowrun (
        .len_i  (value_i),
        .mask_o (low_mask)
    );

    lmd_span_gen #(.LANES(LANES), .VAL_W(VAL_W), .FROM_HIGH(1'b1)) u_highrun (
        .len_i  (value_i),
        .mask_o (high_mask)
    );

    always_comb begin
        unique case (kind)
            SEL_PARITY:  mask_o = parity_mask;
            SEL_SINGLE:  mask_o = single_mask;
            SEL_LOWRUN:  mask_o = low_mask;
            SEL_HIGHRUN: mask_o = high_mask;
            default:     mask_o = '0;
        endcase
    end
endmodule

// File: rtl/lane_mask_decoder_chk.sv
module lane_mask_decoder_chk #(
    parameter int LANES = 32,
    parameter int VAL_W = $clog2(LANES)
) (
    input logic [1:0]       mode_i,
    input logic [VAL_W-1:0] value_i,
    input logic [LANES-1:0] mask_o
);
    always_comb begin
        if (mode_i == 2'd0 && value_i == '0) begin
            // R1
            parity_all_chk: assert ($countones(mask_o) == LANES);
        end
        if (mode_i == 2'd0 && value_i == VAL_W'(1)) begin
            // R2
            parity_odd_chk: assert (!mask_o[0] && mask_o[1] && $countones(mask_o) == LANES / 2);
        end
        if (mode_i == 2'd0 && value_i == VAL_W'(2)) begin
            // R3
            parity_even_chk: assert (mask_o[0] && !mask_o[1] && $countones(mask_o) == LANES / 2);
        end
        if (mode_i == 2'd0 && int'(value_i) > 2) begin
            // R4
            parity_none_chk: assert (mask_o == '0);
        end
        if (mode_i == 2'd1) begin
            // R5
            single_lane_chk: assert ($countones(mask_o) == 1 && mask_o[value_i]);
        end
        if (mode_i == 2'd2 && value_i != '0) begin
            // R6
            low_run_chk: assert (mask_o[0] && $countones(mask_o) == int'(value_i));
        end
        if (mode_i == 2'd3 && value_i != '0) begin
            // R7
            high_run_chk: assert (mask_o[LANES-1] && $countones(mask_o) == int'(value_i));
        end
        if (mode_i[1] && value_i == '0) begin
            // R8
            run_zero_all_chk: assert ($countones(mask_o) == LANES);
        end
    end
endmodule

bind lane_mask_decoder lane_mask_decoder_chk #(.LANES(LANES), .VAL_W(VAL_W)) u_chk (
    .mode_i  (mode_i),
    .value_i (value_i),
    .mask_o  (mask_o)
);

// File: tb/tb_lane_mask_decoder.sv
module tb_lane_mask_decoder;
    localparam int LANES = 32;
    localparam int VAL_W = 5;

    typedef struct {
        int          mode;
        int          val;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       mode_i = '0;
    logic [VAL_W-1:0] value_i = '0;
    logic [LANES-1:0] mask_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    item_t sb[$];

    always #5 clk = ~clk;

    lane_mask_decoder #(.LANES(LANES), .VAL_W(VAL_W)) dut (
        .mode_i  (mode_i),
        .value_i (value_i),
        .mask_o  (mask_o)
    );

    function automatic logic [31:0] ref_mask(input int m, input int n);
        longint one = 64'd1;
        case (m)
            0: begin
                if (n == 0) return 32'hFFFF_FFFF;   // R1
                if (n == 1) return 32'hAAAA_AAAA;   // R2
                if (n == 2) return 32'h5555_5555;   // R3
                return 32'h0;                       // R4
            end
            1: return 32'((one << n));              // R5
            2: return (n == 0) ? 32'hFFFF_FFFF : 32'((one << n) - 1);             // R6 R8
            default: return (n == 0) ? 32'hFFFF_FFFF : ~32'((one << (32 - n)) - 1); // R7 R8
        endcase
    endfunction

    function automatic string ref_tag(input int m, input int n);
        if (m == 0 && n == 0) return "R1";
        if (m == 0 && n == 1) return "R2";
        if (m == 0 && n == 2) return "R3";
        if (m == 0) return "R4";
        if (m == 1) return "R5";
        if (n == 0) return "R8";
        if (m == 2) return "R6";
        return "R7";
    endfunction

    task automatic drive(input int m, input int n, input string extra);
        item_t it;
        @(posedge clk);
        mode_i  = 2'(m);
        value_i = VAL_W'(n);
        it.mode = m;
        it.val  = n;
        it.exp  = ref_mask(m, n);
        it.tag  = {ref_tag(m, n), extra};
        sb.push_back(it);
    endtask

    // Monitor: compares one scoreboard item per cycle, away from the driving edge
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_checks++;
            if (mask_o !== it.exp) begin
                n_fails++;
                $display("FAIL %s mode=%0d value=%0d actual=%h expected=%h",
                         it.tag, it.mode, it.val, mask_o, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // reset state: inputs held at zero give the all-lanes mask (R1)
        @(negedge clk);
        n_checks++;
        if (mask_o !== 32'hFFFF_FFFF) begin
            n_fails++;
            $display("FAIL R1 reset state actual=%h expected=%h", mask_o, 32'hFFFF_FFFF);
        end
        @(posedge clk);
        rst = 1'b0;

        // ascending exhaustive sweep
        for (int m = 0; m < 4; m++)
            for (int n = 0; n < 32; n++)
                drive(m, n, "");
        // descending sweep: each code follows a different predecessor (R9)
        for (int m = 3; m >= 0; m--)
            for (int n = 31; n >= 0; n--)
                drive(m, n, " R9");
        // alternating between extremes (R9)
        drive(3, 31, " R9");
        drive(2, 1, " R9");
        drive(1, 31, " R9");
        drive(0, 3, " R9");
        drive(3, 1, " R9");

        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule